// File: doc/BRIEF.md
# Programmable Pulse Fault Injector

This block sits in series with a group of signal lines. It can corrupt them with periodic pulses, which lets a simulation or emulation model interference bursts. An internal counter sets the repeat interval in clock cycles. The pulse is high for a programmable number of cycles at the start of each interval. While the pulse is high, the lines selected by a mask carry a faulted value and every other line passes through unchanged. The fault mode sets the faulted value: the inverted input, a forced 0 or a forced 1.

An optional random gate decides once per interval whether that interval's pulse fires. The gate compares a 16-bit LFSR against a programmable threshold. The gated pulse is brought out, so several injectors can run in step from one timing source.

Configuration goes through a small write port into shadow registers. The working copy is loaded from the shadow registers on every cycle while the injector is disabled. While it is enabled, the working copy is loaded only at interval boundaries, so a change never cuts a pulse short.

Top module: `pulse_fault_injector`

## Requirements
- R1: After reset, `pulse_active` is 0 and `line_out` equals `line_in`.
- R2: While enabled, the pulse is active in cycle j after enable rises (j = 0 is the first enabled cycle) when j mod P < W. W is the width register (address 0) and P is the period register (address 1).
- R3: With W = 0 the pulse is never active. With W ≥ P the pulse is always active. A period of 0 acts as a one-cycle interval.
- R4: Only lines whose bit in the mask register (address 2) is 1 are altered. Every other line equals `line_in` in every cycle.
- R5: The control register (address 3) bits [1:0] select the fault mode: 0 or 3 inverts the line, 1 forces it to 0, 2 forces it to 1.
- R6: While `enable` is 0, no pulse is active. Each rise of `enable` restarts the interval count at j = 0.
- R7: A write made while enabled takes effect at the start of the next interval. A write made in the last cycle of an interval takes effect one interval later.
- R8: Control bit 2 turns on the random gate, and control bits [31:16] hold the threshold. An interval's pulse fires only when the LFSR value is at most the threshold, so a threshold of 0 never fires and 0xFFFF always fires. The decision is made once per interval.
- R9: `pulse_active` equals the gated pulse that drives the line multiplexers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the pulse generator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 width, 1 period, 2 mask, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| line_in | input | N | Clean signal lines |
| line_out | output | N | Lines after fault injection |
| pulse_active | output | 1 | Gated pulse, for other injectors |

## Verification
The two functions that meet in the same cycle are a configuration write and the interval wrap. The bench enables the injector and then writes a new width exactly in the last cycle of an interval, so the write strobe and the counter wrap fall on the same clock edge. The scoreboard expects the old width for the whole following interval and the new width only from the interval after that. A second write, made in the middle of an interval, is expected to apply at the very next wrap.

// File: rtl/pulse_fault_injector.sv
module pulse_fault_injector #(
  parameter int N  = 8,
  parameter int CW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] line_out,
  output logic         pulse_active
);

  logic [CW-1:0] sh_width, sh_period, act_width, act_period, cnt;
  logic [N-1:0]  sh_mask, act_mask;
  logic [1:0]    sh_mode, act_mode;
  logic          sh_prob;
  logic [15:0]   sh_thr;
  logic [15:0]   lfsr;
  logic          fire;

  wire wrap   = enable && ({1'b0, cnt} + 1'b1 >= {1'b0, act_period});
  wire reload = !enable || wrap;
  wire roll   = !sh_prob || (lfsr <= sh_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_width  <= '0;
      sh_period <= '0;
      sh_mask   <= '0;
      sh_mode   <= '0;
      sh_prob   <= 1'b0;
      sh_thr    <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: sh_width  <= cfg_wdata[CW-1:0];
        2'd1: sh_period <= cfg_wdata[CW-1:0];
        2'd2: sh_mask   <= cfg_wdata[N-1:0];
        default: begin
          sh_mode <= cfg_wdata[1:0];
          sh_prob <= cfg_wdata[2];
          sh_thr  <= cfg_wdata[31:16];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_width  <= '0;
      act_period <= '0;
      act_mask   <= '0;
      act_mode   <= '0;
      fire       <= 1'b1;
    end else if (reload) begin
      act_width  <= sh_width;
      act_period <= sh_period;
      act_mask   <= sh_mask;
      act_mode   <= sh_mode;
      fire       <= roll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  assign pulse_active = enable && fire && (cnt < act_width);

  logic [N-1:0] faulted;
  always_comb begin
    case (act_mode)
      2'd1:    faulted = '0;
      2'd2:    faulted = '1;
      default: faulted = ~line_in;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_mux
    assign line_out[i] = (pulse_active && act_mask[i]) ? faulted[i] : line_in[i];
  end

endmodule

module pulse_fault_injector_chk #(
  parameter int N  = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [N-1:0]  line_in,
  input logic [N-1:0]  line_out,
  input logic          pulse_active,
  input logic [N-1:0]  act_mask,
  input logic [CW-1:0] act_width,
  input logic [CW-1:0] cnt,
  input logic [15:0]   lfsr
);

  a_r1_clean_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_active |-> line_out == line_in);

  a_r4_unmasked_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_out ^ line_in) & ~act_mask) == '0);

  a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pulse_active);

  a_r6_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);

  a_r7_width_held_mid_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt != '0 && $past(enable)) |-> $stable(act_width));

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);

endmodule

bind pulse_fault_injector pulse_fault_injector_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .line_in(line_in),
  .line_out(line_out), .pulse_active(pulse_active), .act_mask(act_mask),
  .act_width(act_width), .cnt(cnt), .lfsr(lfsr)
);

// File: tb/pulse_fault_injector_bench.sv
module pulse_fault_injector_bench;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [N-1:0] line_in = 0, line_out;
  logic pulse_active;

  always #2.5 clk = ~clk;

  pulse_fault_injector #(.N(N), .CW(16)) u_pulse_fault_injector (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .line_in(line_in),
    .line_out(line_out), .pulse_active(pulse_active));

  typedef struct {
    logic [N-1:0] out;
    logic         pa;
    string        req;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  int cw = 0, cp = 0, cmask = 0, cmode = 0, cfire = 1;

  initial forever begin
    @(negedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (line_out !== it.out || pulse_active !== it.pa) begin
        fails++;
        $display("FAIL %s: out=%h pa=%b expected out=%h pa=%b",
                 it.req, line_out, pulse_active, it.out, it.pa);
      end
    end
  end

  function automatic logic [N-1:0] faulted(logic [N-1:0] x, int mode);
    if (mode == 1) return '0;
    if (mode == 2) return '1;
    return ~x;
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = addr[1:0]; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(int w, int p, int m, int mode, int pe, int thr);
    wr(0, w); wr(1, p); wr(2, m); wr(3, (thr << 16) | (pe << 2) | mode);
    @(negedge clk);
    cw = w; cp = p; cmask = m; cmode = mode;
    cfire = (pe == 0 || thr == 16'hFFFF) ? 1 : 0;
  endtask

  // Runs n enabled cycles; optional width write in cycle wr_at.
  task automatic run(int n, string req, int wr_at = -1, int new_w = 0);
    int sw;
    sw = 1 << 30;
    if (wr_at >= 0) begin
      int p;
      p = (cp == 0) ? 1 : cp;
      sw = ((wr_at / p) + 1) * p;
      if (sw == wr_at + 1) sw += p;
    end
    for (int j = 0; j < n; j++) begin
      item_t it;
      int w, p;
      logic on;
      @(negedge clk);
      enable = 1;
      cfg_we = 0;
      line_in = N'((j * 37 + 5) ^ (j << 3));
      if (j == wr_at) begin
        cfg_we = 1; cfg_addr = 0; cfg_wdata = new_w;
      end
      w = (j >= sw) ? new_w : cw;
      p = (cp == 0) ? 1 : cp;
      on = cfire && ((j % p) < w);
      it.pa = on;
      it.out = on ? ((line_in & ~N'(cmask)) | (faulted(line_in, cmode) & N'(cmask))) : line_in;
      it.req = req;
      q.push_back(it);
    end
    @(negedge clk);
    cfg_we = 0;
    enable = 0;
    if (wr_at >= 0) cw = new_w;
  endtask

  task automatic run_off(int n, string req);
    for (int j = 0; j < n; j++) begin
      item_t it;
      @(negedge clk);
      enable = 0;
      line_in = N'(j * 91 + 3);
      it.pa = 0; it.out = line_in; it.req = req;
      q.push_back(it);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: expired expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(6, "R1 reset defaults");
    setup(3, 8, 8'hFF, 0, 0, 0);
    run(20, "R2 invert all lines");
    setup(2, 5, 8'h5A, 1, 0, 0);
    run(12, "R4 R5 masked force0");
    setup(4, 6, 8'hC3, 2, 0, 0);
    run(12, "R5 force1");
    setup(4, 6, 8'h0F, 3, 0, 0);
    run(12, "R5 mode3 invert");
    setup(0, 4, 8'hFF, 0, 0, 0);
    run(10, "R3 width zero");
    setup(9, 4, 8'hFF, 0, 0, 0);
    run(10, "R3 width over period");
    setup(1, 0, 8'hFF, 2, 0, 0);
    run(6, "R3 period zero");
    setup(2, 4, 8'hFF, 0, 0, 0);
    run_off(6, "R6 disabled");
    run(9, "R6 restart at enable");
    setup(1, 5, 8'hFF, 0, 0, 0);
    run(20, "R7 write mid interval", 2, 3);
    setup(1, 5, 8'hFF, 0, 0, 0);
    run(25, "R7 write on wrap edge", 4, 4);
    setup(2, 4, 8'hFF, 0, 1, 0);
    run(12, "R8 R9 threshold zero never");
    setup(2, 4, 8'hFF, 0, 1, 16'hFFFF);
    run(12, "R8 R9 threshold max always");
    wait (q.size() == 0);
    begin
      int fired;
      fired = 0;
      setup(1, 2, 8'hFF, 0, 1, 16'h8000);
      for (int j = 0; j < 128; j++) begin
        @(negedge clk); enable = 1; #1;
        if (j % 2 == 0 && pulse_active) fired++;
      end
      @(negedge clk); enable = 0;
      checks++;
      if (fired == 0 || fired == 64) begin
        fails++;
        $display("FAIL R8 half threshold: fired=%0d expected between 1 and 63", fired);
      end
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule